// File: doc/BRIEF.md
# Biphase Frame Serializer

This block turns one parallel word into a single-wire serial frame. A frame opens with one biphase-coded start symbol, carries a chosen number of biphase-coded data bits, and closes with one or two stop symbols that are driven as a flat high level. Biphase coding puts a transition in the middle of every coded bit. A one is sent as a low half followed by a high half, and a zero is sent as a high half followed by a low half.

Timing comes from an external strobe, `tick_i`, which fires once per half-bit. Every bit therefore lasts two strobe intervals. The host sets up the word and the frame options and raises `start_i` while the block is idle. The block samples everything on that clock. It then owns the line until the frame is over, and signals the end with a one-clock `done_o` pulse. The line rests high whenever no frame is in flight.

Top module: `biphase_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `line_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: When `start_i` is 1 while `busy_o` is 0, the request is accepted and `busy_o` is 1 from the next clock onward. When `start_i` is 1 while `busy_o` is 1, it is ignored.
- R3: `line_o` changes only on the clock edge at which `tick_i` is 1. Each strobe after acceptance moves the frame forward by exactly one half-bit, so the first strobe after acceptance drives the first half of the start bit. A strobe in the acceptance cycle itself is not counted.
- R4: The start bit is sent as 0 for one half-bit and then 1 for one half-bit.
- R5: A data bit of value 1 is sent as 0 then 1, and a data bit of value 0 is sent as 1 then 0, each half lasting one strobe interval.
- R6: `len_sel_i` gives the data bit count as a plain binary number. The values 5 to 9 and 13 to 17 are used as given. Every other value, including 10, 11 and 12, selects 8 bits.
- R7: When `msb_first_i` is 1, data bit N-1 is sent first and bit 0 last. When it is 0, bit 0 is sent first. Only `data_i[N-1:0]` is sent.
- R8: When `two_stop_i` is 1, the frame ends with two stop bits; when it is 0, with one. Each stop bit holds `line_o` at 1 for both of its half-bits.
- R9: On the first strobe after the last stop half-bit, `busy_o` falls and `done_o` is 1 for exactly one clock. A new request may be accepted in that clock.
- R10: Changes to `data_i`, `len_sel_i`, `msb_first_i` and `two_stop_i` after acceptance have no effect on the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Half-bit strobe, one clock wide |
| start_i | input | 1 | Frame request |
| data_i | input | DATA_W | Word to send |
| len_sel_i | input | LEN_W | Data bit count code |
| msb_first_i | input | 1 | 1: most significant bit first |
| two_stop_i | input | 1 | 1: two stop bits |
| busy_o | output | 1 | Frame in flight |
| done_o | output | 1 | One-clock pulse at frame end |
| line_o | output | 1 | Serial output line |

## Verification
The hardest case to reach from the ports is the boundary between two frames. A request that arrives in the very clock where `done_o` pulses must start a fresh frame. A strobe that lands in the acceptance clock must be skipped. The stimulus raises `start_i` in the same cycle that the previous frame's done pulse is seen. It also runs a phase in which strobes come every clock and a phase with irregular random spacing, so strobes fall on acceptance and end cycles. A second hard case is a new request that arrives mid-frame together with new inputs. To cover it, the bench keeps requesting and changing every configuration input for several clocks after acceptance. The bench's model must then show that nothing changed.

// File: rtl/biphase_tx_pkg.sv
package biphase_tx_pkg;

  // legal data bit count windows, and the fallback count
  localparam int LEN_LO_A    = 5;
  localparam int LEN_HI_A    = 9;
  localparam int LEN_LO_B    = 13;
  localparam int LEN_HI_B    = 17;
  localparam int LEN_DEFAULT = 8;

  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_STOP  = 2'd2
  } slot_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tx_state_e;

  // Level of one half-bit. ph = 0 is the first half.
  function automatic logic half_level(slot_kind_e kind, logic bitv, logic ph);
    logic lvl;
    case (kind)
      SLOT_START: lvl = ph;
      SLOT_DATA:  lvl = ph ? bitv : ~bitv;
      default:    lvl = 1'b1;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/biphase_tx_lenmap.sv
module biphase_tx_lenmap
  import biphase_tx_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [LEN_W-1:0] code_i,
  output logic [LEN_W-1:0] len_o
);

  logic in_a;
  logic in_b;

  always_comb begin
    in_a  = (int'(code_i) >= LEN_LO_A) && (int'(code_i) <= LEN_HI_A);
    in_b  = (int'(code_i) >= LEN_LO_B) && (int'(code_i) <= LEN_HI_B);
    len_o = (in_a || in_b) ? code_i : LEN_W'(LEN_DEFAULT);
  end

endmodule

// File: rtl/biphase_tx_ctrl.sv
module biphase_tx_ctrl
  import biphase_tx_pkg::*;
#(
  parameter int DATA_W = 17,
  parameter int LEN_W  = 5,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              msb_first_i,
  input  logic              two_stop_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              emit_o,
  output slot_kind_e        kind_o,
  output logic              bit_o,
  output logic              phase_o
);

  tx_state_e          state_q, state_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic               ph_q, ph_d;
  logic               done_q, done_d;
  logic [LEN_W-1:0]   len_q;
  logic               msb_q;
  logic               two_q;
  logic [DATA_W-1:0]  data_q;

  logic               accept;
  logic               finish;
  logic [SLOT_W-1:0]  slot_total;
  logic [SLOT_W-1:0]  bit_idx;
  logic [DATA_W-1:0]  data_sh;

  always_comb begin
    accept     = (state_q == ST_IDLE) && start_i;
    slot_total = SLOT_W'(len_q) + SLOT_W'(2) + SLOT_W'(two_q);
    finish     = (state_q == ST_RUN) && tick_i && (slot_q == slot_total);
    emit_o     = (state_q == ST_RUN) && tick_i && (slot_q != slot_total);

    if (slot_q == '0)
      kind_o = SLOT_START;
    else if (slot_q <= SLOT_W'(len_q))
      kind_o = SLOT_DATA;
    else
      kind_o = SLOT_STOP;

    bit_idx = msb_q ? (SLOT_W'(len_q) - slot_q) : (slot_q - SLOT_W'(1));
    data_sh = data_q >> bit_idx;
    bit_o   = data_sh[0];
    phase_o = ph_q;
  end

  // next state
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    ph_d    = ph_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = ST_RUN;
      slot_d  = '0;
      ph_d    = 1'b0;
    end else if (finish) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end else if (emit_o) begin
      ph_d = ~ph_q;
      if (ph_q)
        slot_d = slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      ph_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      ph_q    <= ph_d;
      done_q  <= done_d;
    end
  end

  // frame settings, captured only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LEN_W'(LEN_DEFAULT);
      msb_q  <= 1'b0;
      two_q  <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      len_q  <= len_i;
      msb_q  <= msb_first_i;
      two_q  <= two_stop_i;
      data_q <= data_i;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  // R6: the held count is always one of the legal values during a frame
  a_r6_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |->
      (((int'(len_q) >= LEN_LO_A) && (int'(len_q) <= LEN_HI_A)) ||
       ((int'(len_q) >= LEN_LO_B) && (int'(len_q) <= LEN_HI_B))));

  // R3: without a strobe the frame position does not move
  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && !tick_i) |=> ($stable(slot_q) && $stable(ph_q)));

endmodule

// File: rtl/biphase_tx_line.sv
module biphase_tx_line
  import biphase_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       emit_i,
  input  slot_kind_e kind_i,
  input  logic       bit_i,
  input  logic       phase_i,
  output logic       line_o
);

  logic line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (emit_i)
      line_d = half_level(kind_i, bit_i, phase_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_q <= 1'b1;
    else
      line_q <= line_d;
  end

  assign line_o = line_q;

  // R5: every coded data bit flips the line at its centre
  a_r5_mid_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_i && (kind_i == SLOT_DATA) && phase_i) |=> (line_q != $past(line_q)));

  // R4: the start bit's second half is high
  a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_i && (kind_i == SLOT_START) && phase_i) |=> line_q);

endmodule

// File: rtl/biphase_tx.sv
module biphase_tx
  import biphase_tx_pkg::*;
#(
  parameter  int DATA_W = 17,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  input  logic              msb_first_i,
  input  logic              two_stop_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              line_o
);

  localparam int SLOT_W = $clog2(DATA_W + 4);

  // reset synchronizer: asserts at once, releases on the clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [LEN_W-1:0] len_eff;
  logic             emit;
  slot_kind_e       kind;
  logic             bitv;
  logic             phase;

  biphase_tx_lenmap #(.LEN_W(LEN_W)) u_lenmap (
    .code_i (len_sel_i),
    .len_o  (len_eff)
  );

  biphase_tx_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rs_n),
    .tick_i      (tick_i),
    .start_i     (start_i),
    .data_i      (data_i),
    .len_i       (len_eff),
    .msb_first_i (msb_first_i),
    .two_stop_i  (two_stop_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .emit_o      (emit),
    .kind_o      (kind),
    .bit_o       (bitv),
    .phase_o     (phase)
  );

  biphase_tx_line u_line (
    .clk     (clk),
    .rst_n   (rs_n),
    .emit_i  (emit),
    .kind_i  (kind),
    .bit_i   (bitv),
    .phase_i (phase),
    .line_o  (line_o)
  );

  // R1: the line rests high outside a frame
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rs_n)
    !busy_o |-> line_o);

  // R9: done is a single-clock pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rs_n)
    done_o |=> !done_o);

  // R9: busy only ends together with done
  a_r9_end_with_done: assert property (@(posedge clk) disable iff (!rs_n)
    $fell(busy_o) |-> done_o);

  // R2: an idle request is taken on the next clock
  a_r2_accept: assert property (@(posedge clk) disable iff (!rs_n)
    (start_i && !busy_o) |=> busy_o);

  // R8: stop halves drive the line high
  a_r8_stop_high: assert property (@(posedge clk) disable iff (!rs_n)
    (emit && (kind == SLOT_STOP)) |=> line_o);

endmodule

// File: tb/biphase_tx_tb_top.sv
module biphase_tx_tb_top;

  localparam int DW = 17;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] data = '0;
  logic [LW-1:0] len_sel = 5'd8;
  logic          msb = 1'b0;
  logic          two = 1'b0;
  logic          busy, done, line;

  always #5 clk = ~clk;

  biphase_tx #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start),
    .data_i(data), .len_sel_i(len_sel), .msb_first_i(msb),
    .two_stop_i(two), .busy_o(busy), .done_o(done), .line_o(line)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  // ---------------- reference model ----------------
  typedef struct { bit lvl; string tag; } half_t;
  half_t q[$];
  bit    m_busy, m_done, m_line;
  string m_tag;

  function automatic int eff_len(int code);
    if ((code >= 5 && code <= 9) || (code >= 13 && code <= 17)) return code;
    return 8;
  endfunction

  task automatic push(bit l, string t);
    half_t h;
    h.lvl = l;
    h.tag = t;
    q.push_back(h);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_line = 1; m_tag = "R1";
      q.delete();
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          int n;
          n = eff_len(int'(len_sel));
          q.delete();
          push(0, "R4"); push(1, "R4");
          for (int i = 0; i < n; i++) begin
            bit b;
            b = msb ? data[n-1-i] : data[i];
            push(~b, "R5"); push(b, "R5");
          end
          for (int s = 0; s < (two ? 2 : 1); s++) begin
            push(1, "R8"); push(1, "R8");
          end
          m_busy = 1;
        end
      end else if (tick) begin
        if (q.size() == 0) begin
          m_busy = 0; m_done = 1; m_tag = "R1";
        end else begin
          half_t h;
          h = q.pop_front();
          m_line = h.lvl;
          m_tag  = h.tag;
        end
      end
    end
  end

  task automatic chk(bit act, bit exp, string tag, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s, scenario %s) t=%0t actual=%0b expected=%0b",
               tag, what, cur_req, $time, act, exp);
    end
  endtask

  // compare on every falling edge once out of reset
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(line, m_line, m_tag, "line");
      chk(busy, m_busy, "R2", "busy");
      chk(done, m_done, "R9", "done");
    end
  end

  // ---------------- half-bit strobe source ----------------
  int  tick_per = 3;
  bit  tick_rnd = 0;
  int  tick_cnt = 0;
  always @(negedge clk) begin
    if (tick_cnt <= 0) begin
      tick = 1'b1;
      tick_cnt = tick_rnd ? int'($urandom_range(3, 0)) : tick_per - 1;
    end else begin
      tick = 1'b0;
      tick_cnt--;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(logic [DW-1:0] d, int l, bit m, bit t, bit disturb);
    while (busy) @(negedge clk);
    start = 1; data = d; len_sel = LW'(l); msb = m; two = t;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      // R10 and R2: new requests and new settings mid-frame
      for (int k = 0; k < 10; k++) begin
        start = 1; data = DW'($urandom); len_sel = LW'($urandom_range(17, 0));
        msb = ~msb; two = ~two;
        @(negedge clk);
      end
      start = 0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: state after reset
    cur_req = "R1";
    chk(line, 1'b1, "R1", "reset line");
    chk(busy, 1'b0, "R1", "reset busy");
    chk(done, 1'b0, "R1", "reset done");

    cur_req = "R5";
    send(17'h000A5, 8, 0, 0, 0);
    send(17'h1FFFF, 8, 0, 0, 0);
    send(17'h00000, 8, 0, 1, 0);
    cur_req = "R7";
    send(17'h000A5, 8, 1, 0, 0);
    send(17'h1A5C3, 17, 1, 1, 0);
    send(17'h1A5C3, 17, 0, 0, 0);
    cur_req = "R6";
    send(17'h0001D, 5, 0, 1, 0);
    send(17'h00155, 9, 1, 0, 0);
    send(17'h01ABC, 13, 0, 1, 0);
    send(17'h0ABCD, 16, 1, 0, 0);
    send(17'h003C7, 10, 0, 0, 0);
    send(17'h003C7, 11, 1, 0, 0);
    send(17'h003C7, 12, 0, 1, 0);
    send(17'h0005A, 0, 0, 0, 0);
    send(17'h0005A, 31, 1, 0, 0);
    cur_req = "R10";
    send(17'h12345, 14, 0, 1, 1);
    send(17'h054AB, 7, 1, 0, 1);
    cur_req = "R3";
    tick_per = 1;
    send(17'h0F0F0, 15, 0, 0, 0);
    send(17'h0003F, 6, 1, 1, 0);
    tick_rnd = 1;
    for (int k = 0; k < 6; k++)
      send(DW'($urandom), int'($urandom_range(17, 0)), k[0], k[1], 0);
    cur_req = "R9";
    tick_rnd = 0; tick_per = 2;
    send(17'h00011, 5, 0, 0, 0);
    send(17'h00022, 5, 1, 0, 0);
    repeat (10) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule